// File: doc/BRIEF.md
# Terminal Address Latch with Lock

This block keeps the remote terminal's bus address in a small status word. The word holds five address bits, one parity bit, a lock bit and an eight-bit field of other host-writable bits. While the active-low master reset is held low, the whole word is cleared. On the first clock edge after the reset is released, the block loads the address pins, the parity pin and the lock pin into the word. It ignores those pins from then until the next master reset.

After that capture the host can change the word through a write port that carries a data word and a write mask with one bit per register bit. Writes to the other field always take effect. Writes to the address and parity bits take effect only while the captured lock bit is low. The lock bit itself cannot be written. The terminal logic uses `activeAddr`, which always comes from the stored word and never from the pins. It also uses `parityOk`, which shows whether the stored address and parity bits together have odd parity.

Top module: `term_addr_latch`

## Requirements
- R1: While `mrN` is low, `statusWord`, `activeAddr`, `parityOk` and `lockOut` are all zero.
- R2: On the first rising clock edge with `mrN` high, the word loads `pinAddr` into bits 12:8, `pinPar` into bit 13 and `pinLock` into bit 14. Bits 7:0 and bit 15 become zero.
- R3: After that capture, changes on `pinAddr`, `pinPar` and `pinLock` have no effect on any output.
- R4: While the lock bit is 0, a write (`wrEn` high at a clock edge) sets each of bits 13:8 whose `wrMask` bit is 1 to the `wrData` bit. Bits 13:8 whose mask bit is 0 stay unchanged.
- R5: While the lock bit is 1, a write leaves bits 13:8 unchanged.
- R6: A write updates the bits of 7:0 selected by `wrMask` from `wrData`, whatever the lock bit is.
- R7: Bit 14 (lock) and bit 15 (always 0) are never changed by a write. The lock bit holds until the next master reset.
- R8: `parityOk` is 1 exactly when the XOR of bits 13:8 of `statusWord` is 1. It follows the word in the same cycle that the word changes.
- R9: `activeAddr` always equals bits 12:8 of `statusWord`.
- R10: A write that is presented on the capture edge is ignored. The captured pin values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrN | input | 1 | Master reset, active low; clears the word while low |
| pinAddr | input | 5 | Terminal address pins, captured after reset |
| pinPar | input | 1 | Address parity pin, captured after reset |
| pinLock | input | 1 | Lock pin, captured after reset |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 16 | Host write data |
| wrMask | input | 16 | Per-bit write enable mask |
| statusWord | output | 16 | Stored status word |
| activeAddr | output | 5 | Active terminal address from the word |
| parityOk | output | 1 | Stored address plus parity has odd parity |
| lockOut | output | 1 | Captured lock bit |

## Verification
The assertions check the following on every cycle: the cleared state during reset, that each capture takes the pin values, that the lock bit holds, that address and parity stay fixed while locked, that the word stays stable with no write, and that `parityOk` agrees with the stored bits. Only the bench scenarios can show that masked writes land on exactly the selected bits. The bench also shows that pin changes after capture are ignored and that a write on the capture edge loses. For these, the bench sweeps every address, parity and lock combination and computes each expected word arithmetically.

// File: rtl/term_addr_pkg.sv
package term_addr_pkg;

  typedef struct packed {
    logic capture;
    logic wrAddr;
    logic wrOther;
  } addrStrobe_t;

endpackage

// File: rtl/term_addr_ctrl.sv
module term_addr_ctrl
  import term_addr_pkg::*;
(
  input  logic        clk,
  input  logic        mrN,
  input  logic        wrEn,
  input  logic        lockBit,
  output addrStrobe_t strobe
);

  logic captured;

  always_ff @(posedge clk or negedge mrN) begin
    if (!mrN) captured <= 1'b0;
    else      captured <= 1'b1;
  end

  always_comb begin
    strobe.capture = !captured;
    strobe.wrOther = captured && wrEn;
    strobe.wrAddr  = captured && wrEn && !lockBit;
  end

endmodule

// File: rtl/term_addr_dp.sv
module term_addr_dp
  import term_addr_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int OTHER_W = 8,
  localparam int REG_W  = OTHER_W + ADDR_W + 3,
  localparam int ADDR_LSB = OTHER_W,
  localparam int PAR_POS  = OTHER_W + ADDR_W,
  localparam int LOCK_POS = PAR_POS + 1
)(
  input  logic               clk,
  input  logic               mrN,
  input  addrStrobe_t        strobe,
  input  logic [ADDR_W-1:0]  pinAddr,
  input  logic               pinPar,
  input  logic               pinLock,
  input  logic [REG_W-1:0]   wrData,
  input  logic [REG_W-1:0]   wrMask,
  output logic [REG_W-1:0]   word,
  output logic               parityOk,
  output logic               lockBit
);

  logic [ADDR_W-1:0]  addrQ, addrNext, mAddr, dAddr;
  logic               parQ, parNext, lockQ, lockNext;
  logic [OTHER_W-1:0] otherQ, otherNext, mOther, dOther;
  logic               parityQ;

  assign mAddr  = wrMask[ADDR_LSB +: ADDR_W];
  assign dAddr  = wrData[ADDR_LSB +: ADDR_W];
  assign mOther = wrMask[OTHER_W-1:0];
  assign dOther = wrData[OTHER_W-1:0];

  always_comb begin
    addrNext  = addrQ;
    parNext   = parQ;
    lockNext  = lockQ;
    otherNext = otherQ;
    if (strobe.capture) begin
      addrNext  = pinAddr;
      parNext   = pinPar;
      lockNext  = pinLock;
      otherNext = '0;
    end else begin
      if (strobe.wrAddr) begin
        addrNext = (addrQ & ~mAddr) | (dAddr & mAddr);
        parNext  = wrMask[PAR_POS] ? wrData[PAR_POS] : parQ;
      end
      if (strobe.wrOther) otherNext = (otherQ & ~mOther) | (dOther & mOther);
    end
  end

  always_ff @(posedge clk or negedge mrN) begin
    if (!mrN) begin
      addrQ   <= '0;
      parQ    <= 1'b0;
      lockQ   <= 1'b0;
      otherQ  <= '0;
      parityQ <= 1'b0;
    end else begin
      addrQ   <= addrNext;
      parQ    <= parNext;
      lockQ   <= lockNext;
      otherQ  <= otherNext;
      parityQ <= ^{addrNext, parNext};
    end
  end

  assign word     = {1'b0, lockQ, parQ, addrQ, otherQ};
  assign parityOk = parityQ;
  assign lockBit  = lockQ;

endmodule

// File: rtl/term_addr_latch.sv
module term_addr_latch
  import term_addr_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int OTHER_W = 8,
  localparam int REG_W  = OTHER_W + ADDR_W + 3
)(
  input  logic              clk,
  input  logic              mrN,
  input  logic [ADDR_W-1:0] pinAddr,
  input  logic              pinPar,
  input  logic              pinLock,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  input  logic [REG_W-1:0]  wrMask,
  output logic [REG_W-1:0]  statusWord,
  output logic [ADDR_W-1:0] activeAddr,
  output logic              parityOk,
  output logic              lockOut
);

  addrStrobe_t strobe;
  logic        lockBit;

  term_addr_ctrl uCtrl (
    .clk     (clk),
    .mrN     (mrN),
    .wrEn    (wrEn),
    .lockBit (lockBit),
    .strobe  (strobe)
  );

  term_addr_dp #(.ADDR_W(ADDR_W), .OTHER_W(OTHER_W)) uDp (
    .clk      (clk),
    .mrN      (mrN),
    .strobe   (strobe),
    .pinAddr  (pinAddr),
    .pinPar   (pinPar),
    .pinLock  (pinLock),
    .wrData   (wrData),
    .wrMask   (wrMask),
    .word     (statusWord),
    .parityOk (parityOk),
    .lockBit  (lockBit)
  );

  assign activeAddr = statusWord[OTHER_W +: ADDR_W];
  assign lockOut    = lockBit;

endmodule

// File: rtl/term_addr_chk.sv
module term_addr_chk #(
  parameter int ADDR_W  = 5,
  parameter int OTHER_W = 8,
  localparam int REG_W  = OTHER_W + ADDR_W + 3,
  localparam int PAR_POS = OTHER_W + ADDR_W
)(
  input logic              clk,
  input logic              mrN,
  input logic [ADDR_W-1:0] pinAddr,
  input logic              pinPar,
  input logic              pinLock,
  input logic              wrEn,
  input logic [REG_W-1:0]  statusWord,
  input logic [ADDR_W-1:0] activeAddr,
  input logic              parityOk,
  input logic              lockOut
);

  logic afterCap;

  always_ff @(posedge clk or negedge mrN) begin
    if (!mrN) afterCap <= 1'b0;
    else      afterCap <= 1'b1;
  end

  always @(posedge clk) begin
    if (!mrN) begin
      AST_RESET_CLEAR: assert (statusWord == '0 && !parityOk && !lockOut); // R1
    end
  end

  AST_CAPTURE_PINS: assert property (@(posedge clk) disable iff (!mrN)
    !afterCap |=> (activeAddr == $past(pinAddr) && statusWord[PAR_POS] == $past(pinPar)
                   && lockOut == $past(pinLock))); // R2

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!mrN)
    afterCap |=> $stable(lockOut)); // R7

  AST_LOCKED_ADDR: assert property (@(posedge clk) disable iff (!mrN)
    (afterCap && lockOut) |=> $stable(statusWord[PAR_POS:OTHER_W])); // R5

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!mrN)
    (afterCap && !wrEn) |=> $stable(statusWord)); // R3

  AST_PARITY_MATCH: assert property (@(posedge clk) disable iff (!mrN)
    parityOk == ^statusWord[PAR_POS:OTHER_W]); // R8

endmodule

bind term_addr_latch term_addr_chk #(.ADDR_W(ADDR_W), .OTHER_W(OTHER_W)) uChk (
  .clk        (clk),
  .mrN        (mrN),
  .pinAddr    (pinAddr),
  .pinPar     (pinPar),
  .pinLock    (pinLock),
  .wrEn       (wrEn),
  .statusWord (statusWord),
  .activeAddr (activeAddr),
  .parityOk   (parityOk),
  .lockOut    (lockOut)
);

// File: tb/sim_term_addr_latch.sv
`timescale 1ns/1ps
module sim_term_addr_latch;

  logic        clk = 1'b0;
  logic        mrN = 1'b0;
  logic [4:0]  pinAddr = '0;
  logic        pinPar = 1'b0;
  logic        pinLock = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] wrMask = '0;
  logic [15:0] statusWord;
  logic [4:0]  activeAddr;
  logic        parityOk;
  logic        lockOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  term_addr_latch u0 (
    .clk(clk), .mrN(mrN), .pinAddr(pinAddr), .pinPar(pinPar), .pinLock(pinLock),
    .wrEn(wrEn), .wrData(wrData), .wrMask(wrMask), .statusWord(statusWord),
    .activeAddr(activeAddr), .parityOk(parityOk), .lockOut(lockOut)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req, input logic [15:0] expWord);
    check({req, " word"}, statusWord, expWord);
    check({req, " R9 addr"}, {11'd0, activeAddr}, {11'd0, expWord[12:8]});
    check({req, " R8 parity"}, {15'd0, parityOk}, {15'd0, ^expWord[13:8]});
    check({req, " R7 lock"}, {15'd0, lockOut}, {15'd0, expWord[14]});
  endtask

  function automatic logic [15:0] applyWrite(input logic [15:0] w, input logic [15:0] d,
                                             input logic [15:0] m);
    logic [15:0] sel;
    sel = w[14] ? 16'h00FF : 16'h3FFF;
    return (w & ~(m & sel)) | (d & m & sel);
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] expWord, d, m;
    for (int idx = 0; idx < 128; idx++) begin
      logic [4:0] a;
      logic p, l;
      a = idx[4:0];
      p = idx[5];
      l = idx[6];
      // enter reset with unrelated pin values
      @(negedge clk);
      mrN = 1'b0;
      pinAddr = ~a; pinPar = ~p; pinLock = ~l;
      wrEn = 1'b1; wrData = 16'hFFFF; wrMask = 16'hFFFF;
      @(negedge clk);
      checkAll("R1 reset", 16'h0000);
      // release with the real pins; some passes also present a write (R10)
      pinAddr = a; pinPar = p; pinLock = l;
      wrEn = (idx % 4 == 0);
      wrData = {~l, ~l, ~p, ~a, 8'hA5};
      wrMask = 16'hFFFF;
      mrN = 1'b1;
      expWord = {1'b0, l, p, a, 8'h00};
      @(negedge clk);
      checkAll((idx % 4 == 0) ? "R10 R2 capture with write" : "R2 capture", expWord);
      // toggle pins, no write
      wrEn = 1'b0;
      pinAddr = ~a; pinPar = ~p; pinLock = ~l;
      @(negedge clk);
      checkAll("R3 pins ignored", expWord);
      // masked write
      d = 16'(idx * 16'h9E37) ^ 16'h5A5A;
      m = 16'(idx * 16'h3C6B) ^ 16'hC3C3;
      wrEn = 1'b1; wrData = d; wrMask = m;
      @(negedge clk);
      expWord = applyWrite(expWord, d, m);
      checkAll(l ? "R5 R6 locked masked write" : "R4 R6 unlocked masked write", expWord);
      // full-mask write of the complement
      wrData = ~d; wrMask = 16'hFFFF;
      @(negedge clk);
      expWord = applyWrite(expWord, ~d, 16'hFFFF);
      checkAll(l ? "R5 R7 locked full write" : "R4 R7 unlocked full write", expWord);
      check("R7 bit15 zero", {15'd0, statusWord[15]}, 16'd0);
      wrEn = 1'b0;
      @(negedge clk);
      checkAll("R3 hold after writes", expWord);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule